// File: doc/BRIEF.md
# Split-Mode Auto-Reload Timer with Capture

This block is a 16-bit up-counting timer. It can also be set to work as two separate 8-bit counters, each with its own reload byte. It advances only on enable ticks from a small built-in prescaler. The prescaler takes one of two sources: the system clock divided by a fixed ratio, or an external clock that is first synchronized and then divided. Software reads and writes the control, count and reload registers through a plain address/write-enable/data port. Reads are combinational.

A capture mode is also available. The comparator input passes through a two-flop synchronizer. When capture is on, each rising edge of the synchronized comparator signal copies the live count into the reload registers and raises the high flag. Both overflow flags are sticky. A single interrupt request combines the high flag with the low flag, and the low flag can be masked.

Register addresses: 0 control, 1 count low byte, 2 count high byte, 3 reload low byte, 4 reload high byte. Control bits: 7 high flag, 6 low flag, 5 low-flag interrupt enable, 4 capture enable, 3 split enable, 2 run, 1 reserved, 0 source select.

Top module: `split_reload_timer`

## Requirements
- R1: After reset, the control, count and reload registers all read 0x00 and `irq` is low.
- R2: Control bit 1 always reads 0, even after a write of 1 to it.
- R3: With split enable (bit 3) at 0 and run (bit 2) at 1, each tick adds one to the 16-bit count. A tick at 0xFFFF loads the 16-bit reload value and sets the high flag (bit 7).
- R4: With split enable at 1, each byte counts on its own. A byte that ticks at 0xFF loads its own reload byte.
- R5: In split mode, run gates only the high byte. The low byte advances on every tick even when run is 0.
- R6: The low flag (bit 6) sets whenever the low byte ticks at 0xFF, in either mode.
- R7: Hardware never clears either flag. A control write of 0 to a flag bit clears it. A hardware set in the same cycle as that write wins.
- R8: `irq` is high while the high flag is set, or while the low flag is set and the low interrupt enable (bit 5) is 1.
- R9: With capture enable (bit 4) at 1, a rising edge on `cmp_in` copies the count into the reload registers a few cycles later (after two sync flops and edge detection). It also sets the high flag.
- R10: With capture enable at 0, edges on `cmp_in` leave the reload registers and flags unchanged.
- R11: Source select (bit 0) at 0 gives one tick per SYS_DIV clock cycles. At 1 it gives one tick per EXT_DIV synchronized rising edges of `ext_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | BYTE_W | Write data |
| reg_rdata | output | BYTE_W | Read data of the selected register |
| ext_clk | input | 1 | Asynchronous external clock source |
| cmp_in | input | 1 | Asynchronous comparator output |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, divide-by-12 system prescale, divide-by-8 external prescale and two sync stages. It drives `ext_clk` itself and sends exactly eight edges per tick, so every counting test advances by a known number of steps. That makes the full 16-bit wrap, the split reloads and the low-byte flag exact. The system-clock path is checked separately, by the count difference across a fixed window of 120 cycles, which does not depend on the prescaler's phase.

// File: rtl/tmr_pkg.sv
// Shared register selects and control-bit positions for the split-mode timer.
package tmr_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_CNT_LO = 3'd1,
        SEL_CNT_HI = 3'd2,
        SEL_RLD_LO = 3'd3,
        SEL_RLD_HI = 3'd4
    } reg_sel_e;

    localparam int CB_HFLAG = 7;
    localparam int CB_LFLAG = 6;
    localparam int CB_LIE   = 5;
    localparam int CB_CAPEN = 4;
    localparam int CB_SPLIT = 3;
    localparam int CB_RUN   = 2;
    localparam int CB_XSEL  = 0;
endpackage

// File: rtl/tmr_sync_edge.sv
// Synchronizes an asynchronous input through STAGES flops and pulses `rise`
// for one cycle on each 0->1 change of the synchronized value.
// Assumes STAGES >= 2 and an input that stays stable longer than a clock cycle.
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the input through the chain and keep the previous synced value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;

    assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tmr_prescale.sv
// Produces the one-cycle count enable for the timer. Source 0 is a free
// divide-by-SYS_DIV of the system clock. Source 1 counts synchronized rising
// edges of ext_clk and ticks on every EXT_DIV-th one.
// Assumes SYS_DIV >= 2 and EXT_DIV >= 2. Both dividers run all the time.
module tmr_prescale #(
    parameter int SYS_DIV     = 12,
    parameter int EXT_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic ext_clk,
    output logic tick
);
    localparam int SYS_W = $clog2(SYS_DIV);
    localparam int EXT_W = $clog2(EXT_DIV);

    logic [SYS_W-1:0] sys_cnt;
    logic [EXT_W-1:0] ext_cnt;
    logic             sys_tick;
    logic             ext_rise;
    logic             ext_tick;

    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_clk),
        .rise     (ext_rise)
    );

    assign sys_tick = (sys_cnt == SYS_W'(SYS_DIV - 1));
    assign ext_tick = ext_rise && (ext_cnt == EXT_W'(EXT_DIV - 1));

    // System-clock divider: wraps to zero on its terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)        sys_cnt <= '0;
        else if (sys_tick) sys_cnt <= '0;
        else               sys_cnt <= sys_cnt + 1'b1;
    end

    // External-edge divider: advances once per synchronized rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        ext_cnt <= '0;
        else if (ext_tick) ext_cnt <= '0;
        else if (ext_rise) ext_cnt <= ext_cnt + 1'b1;
    end

    assign tick = ext_sel ? ext_tick : sys_tick;

    assert_sys_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sys_tick |=> !sys_tick);
    assert_ext_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_tick |=> (ext_cnt == '0));
endmodule

// File: rtl/tmr_byte_lane.sv
// One byte of the counter. A software write wins over counting. On an
// enabled step it either loads the reload byte (at all-ones, with reload
// set) or adds one, wrapping through zero.
// Assumes the caller works out inc/reload from the mode and the other lane.
module tmr_byte_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         reload,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] rld_val,
    output logic [W-1:0] value,
    output logic         at_max
);
    assign at_max = &value;

    // Count register: write, then reload/step on enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                 value <= '0;
        else if (wr_en)             value <= wr_val;
        else if (inc && at_max && reload) value <= rld_val;
        else if (inc)               value <= value + 1'b1;
    end

    assert_lane_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && at_max && reload && !wr_en) |=> (value == $past(rld_val)));
    assert_lane_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !at_max && !wr_en) |=> (value == $past(value) + 1'b1));
endmodule

// File: rtl/split_reload_timer.sv
// Top level of the timer. Holds the control and reload registers, steers
// the two byte lanes for 16-bit or split operation, performs capture into
// the reload registers, and drives the interrupt request.
// Assumes BYTE_W >= 8 (the control register uses the low 8 bits) and a
// register port driven synchronously to clk.
module split_reload_timer
    import tmr_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYS_DIV     = 12,
    parameter int EXT_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_we,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              ext_clk,
    input  logic              cmp_in,
    output logic              irq
);
    localparam int LANES = 2;

    logic flag_h, flag_l, lie, cap_en, split, run, xsel;
    logic tick, cmp_rise, cap_fire, ctrl_wr;
    logic lo_ovf, hi_ovf;
    logic unused_wbits;

    logic [BYTE_W-1:0] lane_val [LANES];
    logic [BYTE_W-1:0] rld_q    [LANES];
    logic              lane_max [LANES];
    logic              lane_inc [LANES];
    logic              lane_rl  [LANES];
    logic              lane_wr  [LANES];
    logic              rld_wr   [LANES];

    assign unused_wbits = ^reg_wdata[BYTE_W-1:0] & 1'b0 | reg_wdata[1];

    tmr_prescale #(
        .SYS_DIV     (SYS_DIV),
        .EXT_DIV     (EXT_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_sel (xsel),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_cmp_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cmp_in),
        .rise     (cmp_rise)
    );

    assign cap_fire = cap_en & cmp_rise;
    assign ctrl_wr  = reg_we && (reg_addr == SEL_CTRL);

    // Lane steering: split bytes run on their own; 16-bit mode chains them.
    always_comb begin
        if (split) begin
            lane_inc[0] = tick;
            lane_rl[0]  = 1'b1;
            lane_inc[1] = tick & run;
            lane_rl[1]  = 1'b1;
        end else begin
            lane_inc[0] = tick & run;
            lane_rl[0]  = lane_max[1];
            lane_inc[1] = tick & run & lane_max[0];
            lane_rl[1]  = 1'b1;
        end
    end

    assign lo_ovf = lane_inc[0] & lane_max[0];
    assign hi_ovf = lane_inc[1] & lane_max[1];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [2:0] CNT_SEL = (g == 0) ? SEL_CNT_LO : SEL_CNT_HI;
        localparam logic [2:0] RLD_SEL = (g == 0) ? SEL_RLD_LO : SEL_RLD_HI;

        assign lane_wr[g] = reg_we && (reg_addr == CNT_SEL);
        assign rld_wr[g]  = reg_we && (reg_addr == RLD_SEL);

        tmr_byte_lane #(.W(BYTE_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (lane_inc[g]),
            .reload  (lane_rl[g]),
            .wr_en   (lane_wr[g]),
            .wr_val  (reg_wdata),
            .rld_val (rld_q[g]),
            .value   (lane_val[g]),
            .at_max  (lane_max[g])
        );

        // Reload byte: software write first, else capture snapshot.
        always_ff @(posedge clk) begin
            if (!rst_n)         rld_q[g] <= '0;
            else if (rld_wr[g]) rld_q[g] <= reg_wdata;
            else if (cap_fire)  rld_q[g] <= lane_val[g];
        end
    end

    // Control register: sticky flags with hardware set winning, plus mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_h <= 1'b0;
            flag_l <= 1'b0;
            lie    <= 1'b0;
            cap_en <= 1'b0;
            split  <= 1'b0;
            run    <= 1'b0;
            xsel   <= 1'b0;
        end else begin
            flag_h <= hi_ovf | cap_fire | (ctrl_wr ? reg_wdata[CB_HFLAG] : flag_h);
            flag_l <= lo_ovf | (ctrl_wr ? reg_wdata[CB_LFLAG] : flag_l);
            if (ctrl_wr) begin
                lie    <= reg_wdata[CB_LIE];
                cap_en <= reg_wdata[CB_CAPEN];
                split  <= reg_wdata[CB_SPLIT];
                run    <= reg_wdata[CB_RUN];
                xsel   <= reg_wdata[CB_XSEL];
            end
        end
    end

    // Read mux: combinational view of the selected register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_CTRL: begin
                reg_rdata[CB_HFLAG] = flag_h;
                reg_rdata[CB_LFLAG] = flag_l;
                reg_rdata[CB_LIE]   = lie;
                reg_rdata[CB_CAPEN] = cap_en;
                reg_rdata[CB_SPLIT] = split;
                reg_rdata[CB_RUN]   = run;
                reg_rdata[CB_XSEL]  = xsel;
            end
            SEL_CNT_LO: reg_rdata = lane_val[0];
            SEL_CNT_HI: reg_rdata = lane_val[1];
            SEL_RLD_LO: reg_rdata = rld_q[0];
            SEL_RLD_HI: reg_rdata = rld_q[1];
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = flag_h | (flag_l & lie);

    assert_hflag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_ovf |=> flag_h);
    assert_lflag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lo_ovf |=> flag_l);
    assert_hflag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_h && !ctrl_wr) |=> flag_h);
    assert_irq_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_h |-> irq);
    assert_split_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (split && !run && !lane_wr[1]) |=> $stable(lane_val[1]));
    assert_capture_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && !rld_wr[0] && !rld_wr[1]) |=>
        (rld_q[0] == $past(lane_val[0]) && rld_q[1] == $past(lane_val[1])));
endmodule

// File: tb/tb_split_reload_timer.sv
`timescale 1ns/1ps
module tb_split_reload_timer;
    localparam int SYS_DIV = 12;
    localparam int EXT_DIV = 8;
    localparam logic [2:0] A_CTRL = 3'd0, A_CLO = 3'd1, A_CHI = 3'd2,
                           A_RLO = 3'd3, A_RHI = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ext_clk = 1'b0;
    logic       cmp_in = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    split_reload_timer #(
        .BYTE_W(8), .SYS_DIV(SYS_DIV), .EXT_DIV(EXT_DIV), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk(ext_clk),
        .cmp_in(cmp_in), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per falling edge and compares.
    always @(negedge clk) begin
        sb_item_t it;
        if (sb_q.size() != 0) begin
            it = sb_q.pop_front();
            if (it.is_irq) check(it.tag, {7'd0, irq}, it.exp);
            else           check(it.tag, reg_rdata, it.exp);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        it.is_irq = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    // Exactly EXT_DIV external edges per tick keeps the divider aligned.
    task automatic ext_ticks(input int n);
        for (int i = 0; i < n * EXT_DIV; i++) begin
            @(posedge clk); #1; ext_clk = 1'b1;
            repeat (3) @(posedge clk);
            #1; ext_clk = 1'b0;
            repeat (3) @(posedge clk);
        end
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] a0, a1;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        expect_reg(A_CTRL, 8'h00, "R1 ctrl reset");
        expect_reg(A_CLO,  8'h00, "R1 cnt_lo reset");
        expect_reg(A_CHI,  8'h00, "R1 cnt_hi reset");
        expect_reg(A_RLO,  8'h00, "R1 rld_lo reset");
        expect_reg(A_RHI,  8'h00, "R1 rld_hi reset");
        expect_irq(1'b0, "R1 irq reset");

        // R2: reserved bit reads zero
        wr(A_CTRL, 8'h02);
        expect_reg(A_CTRL, 8'h00, "R2 bit1 reads 0");

        // R11: system source, 120 cycles give exactly 10 ticks
        wr(A_CTRL, 8'h04);
        @(posedge clk); #1; reg_addr = A_CLO;
        @(negedge clk); a0 = reg_rdata;
        repeat (120) @(negedge clk);
        a1 = reg_rdata;
        check("R11 sys divide", a1 - a0, 8'd10);
        wr(A_CTRL, 8'h00);

        // R3/R6: 16-bit wrap through 0xFFFF with reload 0x1234
        wr(A_CTRL, 8'h01);
        wr(A_CLO, 8'hFE); wr(A_CHI, 8'hFF);
        wr(A_RLO, 8'h34); wr(A_RHI, 8'h12);
        wr(A_CTRL, 8'h05);
        ext_ticks(1);
        expect_reg(A_CLO, 8'hFF, "R3 step lo");
        expect_reg(A_CHI, 8'hFF, "R3 step hi");
        expect_reg(A_CTRL, 8'h05, "R3 no flag before wrap");
        ext_ticks(1);
        expect_reg(A_CLO, 8'h34, "R3 reload lo");
        expect_reg(A_CHI, 8'h12, "R3 reload hi");
        expect_reg(A_CTRL, 8'hC5, "R3 R6 flags after wrap");
        expect_irq(1'b1, "R8 irq on high flag");

        // R7/R8: sticky flags, software clear, low enable masking
        repeat (10) @(posedge clk);
        expect_reg(A_CTRL, 8'hC5, "R7 flags sticky");
        wr(A_CTRL, 8'h45);
        expect_reg(A_CTRL, 8'h45, "R7 clear high only");
        expect_irq(1'b0, "R8 low flag masked");
        wr(A_CTRL, 8'h65);
        expect_irq(1'b1, "R8 low flag enabled");
        wr(A_CTRL, 8'h25);
        expect_reg(A_CTRL, 8'h25, "R7 clear low");
        expect_irq(1'b0, "R8 irq clears");

        // R6: low wrap in 16-bit mode without a full wrap
        wr(A_CLO, 8'hFF); wr(A_CHI, 8'h00);
        ext_ticks(1);
        expect_reg(A_CLO, 8'h00, "R6 lo wraps to 0");
        expect_reg(A_CHI, 8'h01, "R6 carry into hi");
        expect_reg(A_CTRL, 8'h65, "R6 low flag only");
        expect_irq(1'b1, "R8 irq from low flag");
        wr(A_CTRL, 8'h01);

        // R4/R5: split mode, low byte runs with run=0
        wr(A_RLO, 8'hF0); wr(A_RHI, 8'hA0);
        wr(A_CLO, 8'hFF); wr(A_CHI, 8'hFF);
        wr(A_CTRL, 8'h09);
        ext_ticks(1);
        expect_reg(A_CLO, 8'hF0, "R4 R5 lo reloads with run 0");
        expect_reg(A_CHI, 8'hFF, "R5 hi held by run 0");
        expect_reg(A_CTRL, 8'h49, "R6 low flag in split");
        wr(A_CTRL, 8'h0D);
        ext_ticks(1);
        expect_reg(A_CLO, 8'hF1, "R4 lo steps");
        expect_reg(A_CHI, 8'hA0, "R4 hi reloads own byte");
        expect_reg(A_CTRL, 8'h8D, "R4 high flag in split");

        // R9: capture copies count into reload and raises high flag
        wr(A_CTRL, 8'h01);
        wr(A_CLO, 8'h78); wr(A_CHI, 8'h56);
        wr(A_CTRL, 8'h11);
        @(posedge clk); #1; cmp_in = 1'b1;
        repeat (5) @(posedge clk);
        expect_reg(A_RLO, 8'h78, "R9 capture lo");
        expect_reg(A_RHI, 8'h56, "R9 capture hi");
        expect_reg(A_CTRL, 8'h91, "R9 capture sets high flag");
        expect_irq(1'b1, "R9 capture irq");
        #1 cmp_in = 1'b0;
        repeat (5) @(posedge clk);

        // R10: capture disabled ignores edges
        wr(A_CTRL, 8'h01);
        wr(A_CLO, 8'h11); wr(A_CHI, 8'h22);
        @(posedge clk); #1; cmp_in = 1'b1;
        repeat (5) @(posedge clk);
        expect_reg(A_RLO, 8'h78, "R10 rld_lo unchanged");
        expect_reg(A_RHI, 8'h56, "R10 rld_hi unchanged");
        expect_reg(A_CTRL, 8'h01, "R10 no flag");
        expect_irq(1'b0, "R10 no irq");
        #1 cmp_in = 1'b0;

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule